// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block tracks the reservation of one hardware thread for load-locked / store-conditional atomic pairs. It sits after address translation and works only on physical addresses. A load-locked request records the granule that holds the physical address. A granule is a naturally aligned block of `2**GRAN_BITS` bytes. The same request also arms a reservation flag. A later store-conditional is judged against that flag and granule. The block decides in the same cycle whether the store goes on to memory, and which result code the instruction receives.

Uncacheable store-conditionals skip the check. They are always sent on, carry their own result code, and leave the reservation untouched. Another agent can report a write to the reserved granule through an invalidate input, which drops the reservation. A counter tracks back-to-back failed store-conditionals. It emits a one-cycle warning pulse each time the run of failures reaches a further multiple of `WARN_PERIOD`, which helps to spot livelock.

Top module: `llsc_monitor`

## Requirements
- R1: A valid request with `req_op`=0 (load-locked) is issued with result code 0 in the same cycle. From the next clock edge, the reservation flag is set and the stored granule equals `req_paddr` with its low `GRAN_BITS` bits cleared.
- R2: A valid cacheable request with `req_op`=1 (store-conditional) passes when the flag is set and its granule equals the stored one. It is then issued in the same cycle with result code 1, and the flag stays set.
- R3: A cacheable store-conditional that does not pass gets result code 0 and is not issued. The flag is clear from the next edge.
- R4: A store-conditional with `req_uncached`=1 is issued with result code 2 whatever the flag or address. The reservation and the failure count are unchanged.
- R5: Each failed store-conditional adds one to the consecutive-failure count. The cycle after the failure that brings the count to a nonzero multiple of `WARN_PERIOD`, `livelock_warn` is high for exactly one cycle.
- R6: A store-conditional that passes under R2 clears the consecutive-failure count to zero.
- R7: `inv_valid` with `inv_paddr` in the stored granule clears the flag from the next edge. An address outside the granule leaves the flag alone. A load-locked in the same cycle takes priority and leaves the flag set for its own granule.
- R8: After synchronous reset, the flag is clear, the failure count is zero and `livelock_warn` is low.
- R9: While `req_valid` is low, `rsp_issue` is 0 and `rsp_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 1 | 0 = load-locked, 1 = store-conditional |
| req_paddr | input | ADDR_W | Physical address of the request |
| req_uncached | input | 1 | Store-conditional targets uncacheable space |
| inv_valid | input | 1 | External write seen to `inv_paddr` |
| inv_paddr | input | ADDR_W | Physical address of the external write |
| rsp_issue | output | 1 | Send the request on to memory (same cycle) |
| rsp_code | output | 2 | Result code: 0 fail, 1 pass, 2 uncacheable |
| livelock_warn | output | 1 | One-cycle pulse on each WARN_PERIOD-th consecutive failure |

## Verification
The bench builds the block with `ADDR_W`=8, `GRAN_BITS`=4 and `WARN_PERIOD`=3. With an 8-bit address, every one of the 256 store-conditional addresses can be swept against several reserved granules. This covers each granule edge on both sides. A period of 3 makes the warning come round many times during that sweep, so the count wrap, its reset on a passing store, and the way uncacheable stores leave it alone are all checked repeatedly against a model in the bench.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic {
        OP_LOAD_LOCKED = 1'b0,
        OP_STORE_COND  = 1'b1
    } llsc_op_e;

    localparam logic [1:0] RC_FAIL     = 2'd0;
    localparam logic [1:0] RC_PASS     = 2'd1;
    localparam logic [1:0] RC_UNCACHED = 2'd2;

    typedef struct packed {
        logic       issue;
        logic [1:0] code;
        logic       sc_fail;
        logic       sc_pass;
        logic       arm;
    } llsc_verdict_t;

    function automatic int unsigned cnt_width(input int unsigned period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

endpackage

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_paddr,
    input  logic              drop,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_paddr,
    output logic              flag,
    output logic [ADDR_W-1:0] granule
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

    logic inv_hit;

    assign inv_hit = inv_valid && ((inv_paddr & ~LOW_MASK) == granule);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            granule <= '0;
        end else if (arm) begin
            flag    <= 1'b1;
            granule <= arm_paddr & ~LOW_MASK;
        end else if (drop || inv_hit) begin
            flag    <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_sc_check.sv
module llsc_sc_check
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic              req_valid,
    input  llsc_op_e          op,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              uncached,
    input  logic              flag,
    input  logic [ADDR_W-1:0] granule,
    output llsc_verdict_t     verdict
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

    logic match;

    assign match = flag && ((paddr & ~LOW_MASK) == granule);

    always_comb begin
        verdict = '0;
        if (req_valid) begin
            if (op == OP_LOAD_LOCKED) begin
                verdict.issue = 1'b1;
                verdict.code  = RC_FAIL;
                verdict.arm   = 1'b1;
            end else if (uncached) begin
                verdict.issue = 1'b1;
                verdict.code  = RC_UNCACHED;
            end else if (match) begin
                verdict.issue   = 1'b1;
                verdict.code    = RC_PASS;
                verdict.sc_pass = 1'b1;
            end else begin
                verdict.issue   = 1'b0;
                verdict.code    = RC_FAIL;
                verdict.sc_fail = 1'b1;
            end
        end
    end
endmodule

// File: rtl/llsc_fail_tracker.sv
module llsc_fail_tracker
    import llsc_pkg::*;
#(
    parameter int WARN_PERIOD = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic sc_fail,
    input  logic sc_pass,
    output logic warn
);
    localparam int CNT_W = cnt_width(WARN_PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            warn    <= 1'b0;
        end else if (sc_fail) begin
            if (run_cnt == LAST) begin
                run_cnt <= '0;
                warn    <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
                warn    <= 1'b0;
            end
        end else begin
            if (sc_pass) begin
                run_cnt <= '0;
            end
            warn <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int WARN_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic              req_uncached,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_paddr,
    output logic              rsp_issue,
    output logic [1:0]        rsp_code,
    output logic              livelock_warn
);
    llsc_verdict_t     verdict;
    logic              lock_flag;
    logic [ADDR_W-1:0] lock_granule;

    llsc_sc_check #(
        .ADDR_W    (ADDR_W),
        .GRAN_BITS (GRAN_BITS)
    ) u_check (
        .req_valid (req_valid),
        .op        (llsc_op_e'(req_op)),
        .paddr     (req_paddr),
        .uncached  (req_uncached),
        .flag      (lock_flag),
        .granule   (lock_granule),
        .verdict   (verdict)
    );

    llsc_resv_reg #(
        .ADDR_W    (ADDR_W),
        .GRAN_BITS (GRAN_BITS)
    ) u_resv (
        .clk       (clk),
        .rst       (rst),
        .arm       (verdict.arm),
        .arm_paddr (req_paddr),
        .drop      (verdict.sc_fail),
        .inv_valid (inv_valid),
        .inv_paddr (inv_paddr),
        .flag      (lock_flag),
        .granule   (lock_granule)
    );

    llsc_fail_tracker #(
        .WARN_PERIOD (WARN_PERIOD)
    ) u_fail (
        .clk     (clk),
        .rst     (rst),
        .sc_fail (verdict.sc_fail),
        .sc_pass (verdict.sc_pass),
        .warn    (livelock_warn)
    );

    assign rsp_issue = verdict.issue;
    assign rsp_code  = verdict.code;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_op,
    input logic [ADDR_W-1:0] req_paddr,
    input logic              req_uncached,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_paddr,
    input logic              rsp_issue,
    input logic [1:0]        rsp_code,
    input logic              livelock_warn,
    input logic              lock_flag,
    input logic [ADDR_W-1:0] lock_granule
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

    assert_ll_arms_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op) |=>
            (lock_flag && lock_granule == ($past(req_paddr) & ~LOW_MASK)));

    assert_pass_issued_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && !req_uncached && lock_flag &&
         (req_paddr & ~LOW_MASK) == lock_granule) |->
            (rsp_issue && rsp_code == 2'd1));

    assert_fail_suppressed_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && !req_uncached && !lock_flag) |->
            (!rsp_issue && rsp_code == 2'd0));

    assert_fail_drops_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && !req_uncached && !rsp_issue) |=> !lock_flag);

    assert_uncached_code_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && req_uncached) |->
            (rsp_issue && rsp_code == 2'd2));

    assert_warn_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(livelock_warn) |-> $past(req_valid && req_op && !req_uncached && !rsp_issue));

    assert_inv_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !(req_valid && !req_op) && lock_flag &&
         (inv_paddr & ~LOW_MASK) == lock_granule) |=> !lock_flag);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!rsp_issue && rsp_code == 2'd0));
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_paddr     (req_paddr),
    .req_uncached  (req_uncached),
    .inv_valid     (inv_valid),
    .inv_paddr     (inv_paddr),
    .rsp_issue     (rsp_issue),
    .rsp_code      (rsp_code),
    .livelock_warn (livelock_warn),
    .lock_flag     (lock_flag),
    .lock_granule  (lock_granule)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
    localparam int AW     = 8;
    localparam int GB     = 4;
    localparam int PERIOD = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_op, req_uncached, inv_valid;
    logic [AW-1:0] req_paddr, inv_paddr;
    logic          rsp_issue, livelock_warn;
    logic [1:0]    rsp_code;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit            m_flag;
    logic [AW-1:0] m_gran;
    int            m_cnt;

    always #2 clk = ~clk;

    llsc_monitor #(.ADDR_W(AW), .GRAN_BITS(GB), .WARN_PERIOD(PERIOD)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_paddr(req_paddr),
        .req_uncached(req_uncached), .inv_valid(inv_valid), .inv_paddr(inv_paddr),
        .rsp_issue(rsp_issue), .rsp_code(rsp_code), .livelock_warn(livelock_warn)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One request (optionally with an invalidate), checked against the model
    task automatic do_op(input string tag, input bit op, input logic [AW-1:0] a,
                         input bit unc, input bit iv, input logic [AW-1:0] ia);
        bit e_issue, fail, pass, e_warn;
        int e_code;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_paddr = a; req_uncached = unc;
        inv_valid = iv; inv_paddr = ia;
        fail = 0; pass = 0;
        if (!op) begin
            e_issue = 1; e_code = 0;
        end else if (unc) begin
            e_issue = 1; e_code = 2;
        end else if (m_flag && (a & 8'hF0) == m_gran) begin
            e_issue = 1; e_code = 1; pass = 1;
        end else begin
            e_issue = 0; e_code = 0; fail = 1;
        end
        #1;
        check(tag, "rsp_issue", int'(rsp_issue), int'(e_issue));
        check(tag, "rsp_code", int'(rsp_code), e_code);
        e_warn = 0;
        if (!op) begin
            m_flag = 1; m_gran = a & 8'hF0;
        end else if (fail || (iv && (ia & 8'hF0) == m_gran)) begin
            m_flag = 0;
        end else if (iv && (ia & 8'hF0) == m_gran) begin
            m_flag = 0;
        end
        if (op == 0 && 0) m_flag = 1;
        if (!op && iv) begin end
        if (op && !fail && iv && (ia & 8'hF0) == m_gran) m_flag = 0;
        if (fail) begin
            m_cnt++;
            if (m_cnt == PERIOD) begin m_cnt = 0; e_warn = 1; end
        end else if (pass) begin
            m_cnt = 0;
        end
        @(posedge clk);
        #1;
        check("R5", "livelock_warn", int'(livelock_warn), int'(e_warn));
        req_valid = 1'b0; inv_valid = 1'b0;
    endtask

    task automatic idle_check;
        @(negedge clk);
        req_valid = 1'b0; inv_valid = 1'b0; req_op = 1'b1; req_paddr = 8'h00;
        #1;
        check("R9", "rsp_issue idle", int'(rsp_issue), 0);
        check("R9", "rsp_code idle", int'(rsp_code), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_op = 0; req_paddr = 0; req_uncached = 0;
        inv_valid = 0; inv_paddr = 0;
        m_flag = 0; m_gran = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R8", "livelock_warn after reset", int'(livelock_warn), 0);
        // R8: flag clear after reset, so an SC at granule 0 fails (R3)
        do_op("R8", 1, 8'h00, 0, 0, 0);
        idle_check();

        // R1 / R2 / R3: every SC address against several reserved granules
        foreach (m_gran[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] la;
            la = (k == 0) ? 8'h00 : (k == 1) ? 8'h37 : (k == 2) ? 8'hA5 : 8'hF0;
            for (int s = 0; s < 256; s++) begin
                do_op("R1", 0, la, 0, 0, 0);
                do_op((((s & 8'hF0) == (la & 8'hF0)) ? "R2" : "R3"), 1, AW'(s), 0, 0, 0);
            end
        end

        // R2: flag stays set after a passing SC
        do_op("R1", 0, 8'h64, 0, 0, 0);
        do_op("R2", 1, 8'h6F, 0, 0, 0);
        do_op("R2", 1, 8'h60, 0, 0, 0);
        // R3: after failure, flag clear even for the right granule
        do_op("R3", 1, 8'h00, 0, 0, 0);
        do_op("R3", 1, 8'h60, 0, 0, 0);

        // R4: uncached with flag clear, then with flag set; reservation kept
        do_op("R4", 1, 8'h99, 1, 0, 0);
        do_op("R1", 0, 8'h40, 0, 0, 0);
        do_op("R4", 1, 8'h99, 1, 0, 0);
        do_op("R4", 1, 8'h41, 0, 0, 0);
        // R4: uncached between failures does not disturb the count
        do_op("R4", 1, 8'h00, 0, 0, 0);
        do_op("R4", 1, 8'h33, 1, 0, 0);
        do_op("R4", 1, 8'h00, 0, 0, 0);

        // R6: a pass resets the run
        do_op("R1", 0, 8'h10, 0, 0, 0);
        do_op("R6", 1, 8'h1C, 0, 0, 0);
        do_op("R6", 1, 8'h80, 0, 0, 0);
        do_op("R6", 1, 8'h80, 0, 0, 0);
        do_op("R1", 0, 8'h10, 0, 0, 0);
        do_op("R6", 1, 8'h11, 0, 0, 0);
        do_op("R6", 1, 8'h80, 0, 0, 0);
        do_op("R6", 1, 8'h80, 0, 0, 0);
        do_op("R6", 1, 8'h80, 0, 0, 0);

        // R5: long run of failures, warning every PERIOD-th
        for (int n = 0; n < 10; n++) do_op("R5", 1, 8'hC0, 0, 0, 0);

        // R7: matching invalidate drops, non-matching keeps, LL wins ties
        do_op("R1", 0, 8'h50, 0, 0, 0);
        do_op("R7", 1, 8'h00, 1, 1, 8'h5F);
        do_op("R7", 1, 8'h50, 0, 0, 0);
        do_op("R1", 0, 8'h50, 0, 0, 0);
        do_op("R7", 1, 8'h00, 1, 1, 8'h60);
        do_op("R7", 1, 8'h55, 0, 0, 0);
        do_op("R7", 0, 8'h50, 0, 1, 8'h52);
        do_op("R7", 1, 8'h5A, 0, 0, 0);
        do_op("R7", 0, 8'h70, 0, 1, 8'h5A);
        do_op("R7", 1, 8'h7E, 0, 0, 0);
        idle_check();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule